// File: doc/BRIEF.md
# TDM Slot Serial Transmitter

This block takes audio words that software or a DMA engine pushes into a 32-entry transmit FIFO and shifts them out, one bit per bit-clock strobe, on a single serial data line divided into time slots. A separate frame generator supplies a one-cycle strobe for each rising bit-clock edge, together with the index of the current slot and the index of the current bit inside that slot. At bit zero of every active slot the block takes the oldest FIFO entry, trims it to the programmed word width, places it at the start or at the end of the slot, and sends that slot image most significant bit first. Slot bits the word does not cover carry zeros.

Word width and slot width are programmed separately, and the number of slots per frame is programmable. Slots past the programmed count carry zeros and consume nothing. A request output tells the DMA engine to refill once the FIFO level has dropped to a selectable threshold (half or a quarter of the depth). An empty FIFO at the start of an active slot sends a silent slot and sets a sticky underrun flag. An inconsistent configuration is flagged and stops transmission without losing queued data.

Top module: `tdm_slot_tx`

## Requirements
- R1: After reset, sdata is 0, fifo_level is 0, fifo_full, dreq and underrun are 0.
- R2: With justify_left = 1, the word occupies the first word-length bits of the slot, most significant bit first, and the rest of the slot is 0.
- R3: With justify_left = 0, the word occupies the last word-length bits of the slot, most significant bit first, and the leading bits of the slot are 0.
- R4: word_len encodes the word width as 0 = 8, 1 = 16, 2 = 20, 3 = 24, 4 = 32 bits; FIFO entry bits above the word width are never sent.
- R5: slot_len encodes the slot width as 0 = 8, 1 = 16, 2 = 32 bits; strobes with bit_idx at or beyond the slot width drive 0.
- R6: slot_count accepts 1, 2, 4, 6 or 8; a slot whose slot_idx is not below slot_count sends zeros and does not pop the FIFO.
- R7: While tx_en is 0, sdata is 0 and the FIFO is not popped; pushes are still accepted and the queued words are sent once tx_en returns to 1.
- R8: An empty FIFO at bit 0 of an active slot sends an all-zero slot and sets underrun, which stays set until tx_en is 0.
- R9: dreq is 1 when tx_en is 1 and fifo_level is at most 16 (req_quarter = 0) or at most 8 (req_quarter = 1), else 0.
- R10: cfg_err is 1 when word_len or slot_len is not a listed code, slot_count is not a listed value, or the word width exceeds the slot width; while it is 1, sdata is 0 and nothing is popped.
- R11: The FIFO holds 32 entries in arrival order, fifo_full is 1 at 32 entries, and a push while full is dropped.
- R12: sdata changes only on the clock edge that samples bit_stb; between strobes of an enabled stream it holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tx_en | input | 1 | Transmit enable |
| word_len | input | 3 | Word width code |
| slot_len | input | 2 | Slot width code |
| slot_count | input | 4 | Active slots per frame |
| justify_left | input | 1 | 1 places the word at the slot start, 0 at its end |
| req_quarter | input | 1 | Request threshold: 0 half depth, 1 quarter depth |
| push_valid | input | 1 | Write one word into the FIFO |
| push_data | input | 32 | Word to write |
| fifo_full | output | 1 | FIFO holds 32 entries |
| fifo_level | output | 6 | Number of queued words |
| bit_stb | input | 1 | One-cycle strobe at each rising bit-clock edge |
| slot_idx | input | 3 | Slot index within the frame |
| bit_idx | input | 5 | Bit index within the slot, 0 first |
| sdata | output | 1 | Serial data line |
| dreq | output | 1 | Refill request |
| underrun | output | 1 | Sticky empty-at-slot-start flag |
| cfg_err | output | 1 | Configuration is inconsistent |

## Verification
The bench builds the block with its default depth of 32 and 3-bit slot index, so the full-FIFO drop, both request thresholds (16 and 8) and all eight slot positions of a frame are reachable within one drain of the queue. Every word width and slot width code is exercised under both justifications, and each strobe's expected bit is derived from the bench's own slot-layout model and compared in order by a monitor. Draining all 32 entries while toggling the threshold select walks the request output across both boundaries.

// File: rtl/tdm_tx_pkg.sv
package tdm_tx_pkg;

  localparam int WORD_W = 32;

  typedef enum logic [2:0] {
    WLEN_8  = 3'd0,
    WLEN_16 = 3'd1,
    WLEN_20 = 3'd2,
    WLEN_24 = 3'd3,
    WLEN_32 = 3'd4
  } wlen_e;

  typedef enum logic [1:0] {
    SLEN_8  = 2'd0,
    SLEN_16 = 2'd1,
    SLEN_32 = 2'd2
  } slen_e;

  // Word width in bits, 0 for an unlisted code.
  function automatic logic [5:0] word_bits(input logic [2:0] code);
    case (code)
      WLEN_8:  return 6'd8;
      WLEN_16: return 6'd16;
      WLEN_20: return 6'd20;
      WLEN_24: return 6'd24;
      WLEN_32: return 6'd32;
      default: return 6'd0;
    endcase
  endfunction

  // Slot width in bits, 0 for an unlisted code.
  function automatic logic [5:0] slot_bits(input logic [1:0] code);
    case (code)
      SLEN_8:  return 6'd8;
      SLEN_16: return 6'd16;
      SLEN_32: return 6'd32;
      default: return 6'd0;
    endcase
  endfunction

  function automatic logic count_ok(input logic [3:0] cnt);
    return (cnt == 4'd1) || (cnt == 4'd2) || (cnt == 4'd4) ||
           (cnt == 4'd6) || (cnt == 4'd8);
  endfunction

  // Builds the slot image: bit 31 is the first bit on the line.
  function automatic logic [WORD_W-1:0] place_word(input logic [WORD_W-1:0] w,
                                                   input logic [5:0] wb,
                                                   input logic [5:0] sb,
                                                   input logic left);
    logic [WORD_W-1:0] mask;
    logic [WORD_W-1:0] trimmed;
    mask    = (wb >= 6'd32) ? '1 : ((32'd1 << wb) - 32'd1);
    trimmed = w & mask;
    if (left) return trimmed << (6'd32 - wb);
    else      return trimmed << (6'd32 - sb);
  endfunction

endpackage

// File: rtl/tdm_tx_fifo.sv
module tdm_tx_fifo #(
  parameter int DEPTH = 32,
  parameter int DW    = 32,
  localparam int AW   = $clog2(DEPTH),
  localparam int LW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [DW-1:0] wdata,
  input  logic          pop,
  output logic [DW-1:0] rdata,
  output logic [LW-1:0] level,
  output logic          full,
  output logic          empty
);

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic          push_ok, pop_ok;

  assign full    = (level == LW'(DEPTH));
  assign empty   = (level == '0);
  assign push_ok = push && !full;
  assign pop_ok  = pop && !empty;
  assign rdata   = mem[rd_ptr];

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_ptr] <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      level  <= '0;
    end else begin
      if (push_ok) wr_ptr <= bump(wr_ptr);
      if (pop_ok)  rd_ptr <= bump(rd_ptr);
      case ({push_ok, pop_ok})
        2'b10:   level <= level + LW'(1);
        2'b01:   level <= level - LW'(1);
        default: level <= level;
      endcase
    end
  end

endmodule

// File: rtl/tdm_tx_shift.sv
module tdm_tx_shift #(
  parameter int WORD_W = 32,
  localparam int BW    = $clog2(WORD_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              active,
  input  logic              bit_stb,
  input  logic [BW-1:0]     bit_idx,
  input  logic [5:0]        slot_w,
  input  logic [WORD_W-1:0] load_img,
  output logic              sdata
);

  logic [WORD_W-1:0] img_q;
  logic [WORD_W-1:0] cur_img;
  logic              first_bit;
  logic              bit_now;

  assign first_bit = (bit_idx == '0);
  assign cur_img   = first_bit ? load_img : img_q;
  assign bit_now   = ({1'b0, bit_idx} < slot_w) ?
                     cur_img[BW'(WORD_W - 1) - bit_idx] : 1'b0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      img_q <= '0;
      sdata <= 1'b0;
    end else if (!active) begin
      img_q <= '0;
      sdata <= 1'b0;
    end else if (bit_stb) begin
      if (first_bit) img_q <= load_img;
      sdata <= bit_now;
    end
  end

endmodule

// File: rtl/tdm_slot_tx.sv
module tdm_slot_tx
  import tdm_tx_pkg::*;
#(
  parameter int DEPTH   = 32,
  parameter int SLOT_IW = 3,
  localparam int LW     = $clog2(DEPTH + 1),
  localparam int BW     = $clog2(WORD_W),
  localparam int HALF   = DEPTH / 2,
  localparam int QUART  = DEPTH / 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               tx_en,
  input  logic [2:0]         word_len,
  input  logic [1:0]         slot_len,
  input  logic [3:0]         slot_count,
  input  logic               justify_left,
  input  logic               req_quarter,
  input  logic               push_valid,
  input  logic [WORD_W-1:0]  push_data,
  output logic               fifo_full,
  output logic [LW-1:0]      fifo_level,
  input  logic               bit_stb,
  input  logic [SLOT_IW-1:0] slot_idx,
  input  logic [BW-1:0]      bit_idx,
  output logic               sdata,
  output logic               dreq,
  output logic               underrun,
  output logic               cfg_err
);

  logic [5:0]        wb, sb;
  logic              cfg_ok, active, fifo_empty;
  logic              slot_in_frame, slot_start_evt, pop_evt;
  logic [WORD_W-1:0] head_word, load_img;

  assign wb     = word_bits(word_len);
  assign sb     = slot_bits(slot_len);
  assign cfg_ok = (wb != 6'd0) && (sb != 6'd0) && count_ok(slot_count) && (wb <= sb);
  assign cfg_err = !cfg_ok;
  assign active  = tx_en && cfg_ok;

  // Named events for the checker.
  assign slot_in_frame  = (4'(slot_idx) < slot_count);
  assign slot_start_evt = active && bit_stb && (bit_idx == '0) && slot_in_frame;
  assign pop_evt        = slot_start_evt && !fifo_empty;

  assign load_img = pop_evt ? place_word(head_word, wb, sb, justify_left) : '0;

  assign dreq = tx_en && (fifo_level <= (req_quarter ? LW'(QUART) : LW'(HALF)));

  tdm_tx_fifo #(.DEPTH(DEPTH), .DW(WORD_W)) i_fifo (
    .clk   (clk),
    .rst_n (rst_n),
    .push  (push_valid),
    .wdata (push_data),
    .pop   (pop_evt),
    .rdata (head_word),
    .level (fifo_level),
    .full  (fifo_full),
    .empty (fifo_empty)
  );

  tdm_tx_shift #(.WORD_W(WORD_W)) i_shift (
    .clk      (clk),
    .rst_n    (rst_n),
    .active   (active),
    .bit_stb  (bit_stb),
    .bit_idx  (bit_idx),
    .slot_w   (sb),
    .load_img (load_img),
    .sdata    (sdata)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                            underrun <= 1'b0;
    else if (!tx_en)                       underrun <= 1'b0;
    else if (slot_start_evt && fifo_empty) underrun <= 1'b1;
  end

endmodule

// File: rtl/tdm_slot_tx_chk.sv
module tdm_slot_tx_chk #(
  parameter int DEPTH   = 32,
  parameter int SLOT_IW = 3,
  localparam int LW     = $clog2(DEPTH + 1)
) (
  input logic               clk,
  input logic               rst_n,
  input logic               tx_en,
  input logic               bit_stb,
  input logic [4:0]         bit_idx,
  input logic [SLOT_IW-1:0] slot_idx,
  input logic [3:0]         slot_count,
  input logic               sdata,
  input logic               dreq,
  input logic               underrun,
  input logic               cfg_err,
  input logic [LW-1:0]      fifo_level,
  input logic               fifo_full,
  input logic               push_valid,
  input logic               pop_evt,
  input logic               slot_start_evt
);

  a_r7_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_en |=> (sdata == 1'b0));

  a_r12_hold_between: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_en && !bit_stb) |=> $stable(sdata));

  a_r6_pop_window: assert property (@(posedge clk) disable iff (!rst_n)
    pop_evt |-> (bit_stb && (bit_idx == 5'd0) && (4'(slot_idx) < slot_count)));

  a_r10_err_no_pop: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |-> !pop_evt);

  a_r8_underrun_set: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_start_evt && (fifo_level == '0)) |=> underrun);

  a_r9_dreq_level: assert property (@(posedge clk) disable iff (!rst_n)
    dreq |-> (tx_en && (fifo_level <= LW'(DEPTH / 2))));

  a_r11_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_full && push_valid && !pop_evt) |=> fifo_full);

  a_r11_level_bound: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_level <= LW'(DEPTH));

endmodule

bind tdm_slot_tx tdm_slot_tx_chk #(.DEPTH(DEPTH), .SLOT_IW(SLOT_IW)) i_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .tx_en          (tx_en),
  .bit_stb        (bit_stb),
  .bit_idx        (bit_idx),
  .slot_idx       (slot_idx),
  .slot_count     (slot_count),
  .sdata          (sdata),
  .dreq           (dreq),
  .underrun       (underrun),
  .cfg_err        (cfg_err),
  .fifo_level     (fifo_level),
  .fifo_full      (fifo_full),
  .push_valid     (push_valid),
  .pop_evt        (pop_evt),
  .slot_start_evt (slot_start_evt)
);

// File: tb/test_tdm_slot_tx.sv
module test_tdm_slot_tx;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tx_en = 1'b0;
  logic [2:0]  word_len = 3'd1;
  logic [1:0]  slot_len = 2'd1;
  logic [3:0]  slot_count = 4'd2;
  logic        justify_left = 1'b1;
  logic        req_quarter = 1'b0;
  logic        push_valid = 1'b0;
  logic [31:0] push_data = '0;
  logic        fifo_full;
  logic [5:0]  fifo_level;
  logic        bit_stb = 1'b0;
  logic [2:0]  slot_idx = '0;
  logic [4:0]  bit_idx = '0;
  logic        sdata, dreq, underrun, cfg_err;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;
  logic due = 1'b0;
  logic  exp_q[$];
  string tag_q[$];

  always #(CLK_P / 2) clk = ~clk;

  tdm_slot_tx i_tdm_slot_tx (
    .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .word_len(word_len),
    .slot_len(slot_len), .slot_count(slot_count), .justify_left(justify_left),
    .req_quarter(req_quarter), .push_valid(push_valid), .push_data(push_data),
    .fifo_full(fifo_full), .fifo_level(fifo_level), .bit_stb(bit_stb),
    .slot_idx(slot_idx), .bit_idx(bit_idx), .sdata(sdata), .dreq(dreq),
    .underrun(underrun), .cfg_err(cfg_err)
  );

  task automatic check(input bit ok, input string rq, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", rq, act, exp);
    end
  endtask

  // Bench widths from the codes in R4 and R5.
  function automatic int wbits(input logic [2:0] c);
    case (c) 3'd0: return 8; 3'd1: return 16; 3'd2: return 20; 3'd3: return 24;
      default: return 32; endcase
  endfunction
  function automatic int sbits(input logic [1:0] c);
    case (c) 2'd0: return 8; 2'd1: return 16; default: return 32; endcase
  endfunction

  // Expected line bit b of a slot carrying w (R2, R3, R4, R5).
  function automatic logic exp_bit(input logic [31:0] w, input bit has, input int b);
    int wb, sb, off;
    wb = wbits(word_len);
    sb = sbits(slot_len);
    if (!has || b >= sb) return 1'b0;
    off = justify_left ? 0 : sb - wb;
    if (b < off || b >= off + wb) return 1'b0;
    return w[wb - 1 - (b - off)];
  endfunction

  // Monitor: scoreboard compare one cycle after each strobe edge.
  always @(posedge clk) due <= bit_stb;
  always @(negedge clk) begin
    if (due) begin
      if (exp_q.size() == 0) begin
        check(0, "R12", int'(sdata), -1);
      end else begin
        logic  e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(sdata === e, t, int'(sdata), int'(e));
      end
    end
  end

  task automatic strobe(input int s, input int b, input logic e, input string rq);
    @(negedge clk);
    bit_stb  = 1'b1;
    slot_idx = 3'(s);
    bit_idx  = 5'(b);
    exp_q.push_back(e);
    tag_q.push_back(rq);
    @(negedge clk);
    bit_stb = 1'b0;
  endtask

  task automatic tx_slot(input int s, input int nbits, input logic [31:0] w,
                         input bit has, input string rq);
    for (int b = 0; b < nbits; b++) strobe(s, b, exp_bit(w, has, b), rq);
  endtask

  task automatic push(input logic [31:0] d);
    @(negedge clk);
    push_valid = 1'b1;
    push_data  = d;
    @(negedge clk);
    push_valid = 1'b0;
  endtask

  initial begin
    #(CLK_P * 150000);
    n_fail++;
    $display("FAIL watchdog: actual 0 expected 1");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(sdata == 0, "R1", int'(sdata), 0);
    check(fifo_level == 0, "R1", int'(fifo_level), 0);
    check(!fifo_full && !dreq && !underrun, "R1", int'({fifo_full, dreq, underrun}), 0);
    check(!cfg_err, "R10", int'(cfg_err), 0);

    // R2 left-justified 16 in 16
    push(32'h0000A5C3); push(32'h00001234);
    tx_en = 1'b1;
    tx_slot(0, 16, 32'h0000A5C3, 1, "R2");
    tx_slot(1, 16, 32'h00001234, 1, "R2");
    check(fifo_level == 0, "R11", int'(fifo_level), 0);

    // R3 right-justified 8 in 16, and left 8 in 16 leaves tail zero
    word_len = 3'd0; justify_left = 1'b0;
    push(32'h00000081);
    tx_slot(0, 16, 32'h81, 1, "R3");
    justify_left = 1'b1;
    push(32'h000000C5);
    tx_slot(1, 16, 32'hC5, 1, "R2");

    // R4 each word width, upper entry bits masked
    slot_len = 2'd2; word_len = 3'd2; justify_left = 1'b0;
    push(32'hFFF9ABCD);
    tx_slot(0, 32, 32'hFFF9ABCD, 1, "R4");
    word_len = 3'd3; justify_left = 1'b1;
    push(32'h7E123456);
    tx_slot(1, 32, 32'h7E123456, 1, "R4");
    word_len = 3'd4;
    push(32'hDEADBEEF);
    tx_slot(0, 32, 32'hDEADBEEF, 1, "R4");
    word_len = 3'd0; slot_len = 2'd1;
    push(32'hFFFFFF5A);
    tx_slot(1, 16, 32'hFFFFFF5A, 1, "R4");

    // R5 8-bit slot: bits beyond width are zero
    slot_len = 2'd0;
    push(32'h000000FF);
    tx_slot(0, 32, 32'hFF, 1, "R5");

    // R6 slot count limits
    slot_count = 4'd1;
    push(32'h000000A7);
    tx_slot(1, 8, 32'h0, 0, "R6");
    check(fifo_level == 1, "R6", int'(fifo_level), 1);
    slot_count = 4'd6;
    tx_slot(5, 8, 32'hA7, 1, "R6");
    push(32'h0000003C);
    tx_slot(6, 8, 32'h0, 0, "R6");
    check(fifo_level == 1, "R6", int'(fifo_level), 1);

    // R7 disabled: silent, no pop, then resumes
    tx_en = 1'b0;
    push(32'h0000005A);
    tx_slot(0, 8, 32'h0, 0, "R7");
    check(fifo_level == 2, "R7", int'(fifo_level), 2);
    tx_en = 1'b1;
    tx_slot(0, 8, 32'h3C, 1, "R7");
    tx_slot(1, 8, 32'h5A, 1, "R7");

    // R10 configuration errors
    word_len = 3'd4; slot_len = 2'd1;
    push(32'h0000BEEF);
    @(negedge clk);
    check(cfg_err == 1, "R10", int'(cfg_err), 1);
    tx_slot(0, 4, 32'h0, 0, "R10");
    check(fifo_level == 1, "R10", int'(fifo_level), 1);
    word_len = 3'd1; slot_count = 4'd3;
    @(negedge clk);
    check(cfg_err == 1, "R10", int'(cfg_err), 1);
    slot_count = 4'd2; word_len = 3'd5;
    @(negedge clk);
    check(cfg_err == 1, "R10", int'(cfg_err), 1);
    word_len = 3'd1;
    @(negedge clk);
    check(cfg_err == 0, "R10", int'(cfg_err), 0);
    tx_slot(0, 16, 32'hBEEF, 1, "R10");

    // R11 / R9 fill past full, drain in order with both thresholds
    tx_en = 1'b0; word_len = 3'd0; slot_len = 2'd0; slot_count = 4'd8;
    justify_left = 1'b1;
    for (int i = 0; i < 33; i++) push(32'hABCDEF00 | 32'((i * 37 + 11) & 8'hFF));
    check(fifo_level == 32, "R11", int'(fifo_level), 32);
    check(fifo_full == 1, "R11", int'(fifo_full), 1);
    check(dreq == 0, "R9", int'(dreq), 0);
    tx_en = 1'b1;
    for (int i = 0; i < 32; i++) begin
      int lvl, thr;
      req_quarter = 1'(i % 2);
      lvl = 32 - i;
      thr = req_quarter ? 8 : 16;
      @(negedge clk);
      check(dreq == (lvl <= thr), "R9", int'(dreq), int'(lvl <= thr));
      tx_slot(i % 8, 8, 32'((i * 37 + 11) & 8'hFF), 1, "R11");
    end
    check(fifo_level == 0, "R11", int'(fifo_level), 0);
    check(dreq == 1, "R9", int'(dreq), 1);

    // R8 underrun
    check(underrun == 0, "R8", int'(underrun), 0);
    tx_slot(0, 8, 32'h0, 0, "R8");
    check(underrun == 1, "R8", int'(underrun), 1);
    push(32'h00000011);
    tx_slot(1, 8, 32'h11, 1, "R8");
    check(underrun == 1, "R8", int'(underrun), 1);
    tx_en = 1'b0;
    @(negedge clk); @(negedge clk);
    check(underrun == 0, "R8", int'(underrun), 0);
    check(dreq == 0, "R9", int'(dreq), 0);

    repeat (3) @(negedge clk);
    check(exp_q.size() == 0, "R12", exp_q.size(), 0);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule